// File: doc/BRIEF.md
# Software Security Level Controller

This block holds the software security byte of an in-system programming loader and acts as the gatekeeper for every command that the loader's protocol engine decodes. The engine presents one command per request strobe as a class code, plus a data byte and a target select where the class needs them. One cycle later the block answers with an allow/deny decision. For a refusal it also gives the ASCII error character that the engine must send back ahead of CR LF.

The security byte has three valid encodings: open, write-protected and read/write-protected. A security write can only raise the level, and only a full chip erase brings it back to open. A full erase also returns the boot status byte and the boot vector byte to their erased values. Both of these bytes are held here, because their writes are gated by the level. The non-volatile copy of the security byte is modelled as a register with a load port, which the surrounding logic drives at start-up. The memory operations themselves are carried out elsewhere.

Top module: `secGate`

## Requirements
- R1: `secLevel` reports 0 for security byte FFh, 1 for FEh and 2 for FCh. Any other byte value is treated as level 2 for every decision: a memory read is denied with 'L' and a memory write with 'P'.
- R2: Class codes are: 0 memory write, 1 memory read, 2 configuration write, 3 configuration read, 4 security write, 5 block erase, 6 full erase, 7 blank check, 8 identification read. Each accepted `reqValid` cycle produces `respValid` high for exactly the following cycle. An allowed command reports `respAllow`=1 and `respChar`=00h. At level 0 every defined class is allowed.
- R3: At level 1, memory writes and configuration writes are denied with 'P' (50h), while memory reads and configuration reads are allowed.
- R4: At level 2, memory reads and configuration reads are denied with 'L' (4Ch), and memory writes and configuration writes are denied with 'P'.
- R5: Block erase is allowed only at level 0 and is otherwise denied with 'P'. Full erase, blank check and identification read are allowed at every level.
- R6: An allowed full erase sets the security byte to FFh, the boot status byte to FFh and the boot vector byte to FCh.
- R7: A security write carries the requested encoding in `reqData`. It is allowed, and stores that byte, only if the encoding is valid and names a strictly higher level than the current one. Otherwise it is denied with 'P' and the byte is unchanged.
- R8: An allowed configuration write stores `reqData` into the boot status byte when `reqSel`=0 and into the boot vector byte when `reqSel`=1. A denied one changes neither byte.
- R9: `loadValid` writes `loadData` into the security byte at any level, and takes priority over a security write or full erase in the same cycle.
- R10: After reset the security byte is FFh, the boot status byte FFh, the boot vector byte FCh, and `respValid` is 0.
- R11: Class codes 9 to 15 are denied with 'P' at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Command request strobe |
| reqClass | input | 4 | Command class code |
| reqSel | input | 1 | Configuration target: 0 boot status, 1 boot vector |
| reqData | input | 8 | Value for security or configuration writes |
| loadValid | input | 1 | Load strobe from non-volatile storage |
| loadData | input | 8 | Security byte value to load |
| respValid | output | 1 | Decision valid, one cycle after the request |
| respAllow | output | 1 | 1 when the command may proceed |
| respChar | output | 8 | Error character when denied, 00h when allowed |
| secLevel | output | 2 | Current decoded security level |
| secByte | output | 8 | Current security byte |
| bootStatus | output | 8 | Boot status byte |
| bootVector | output | 8 | Boot vector byte |

## Verification
The level-monotonic and erase-default properties assume that the load port is quiet in the cycle they examine. For that reason each property is conditioned on `loadValid` being low. The bench raises `loadValid` only in cycles of its own, between commands, except in the single directed case that tests load priority. The response properties assume one request per cycle with a class code held stable for that cycle. The bench drives each request for one cycle on the falling edge and waits for its answer before sending the next.

// File: rtl/secGatePkg.sv
package secGatePkg;

  localparam int SEC_W   = 8;
  localparam int CLASS_W = 4;

  localparam logic [SEC_W-1:0] CODE_OPEN   = 8'hFF;
  localparam logic [SEC_W-1:0] CODE_WPROT  = 8'hFE;
  localparam logic [SEC_W-1:0] CODE_RWPROT = 8'hFC;

  localparam logic [SEC_W-1:0] CHAR_WDENY = 8'h50;  // 'P'
  localparam logic [SEC_W-1:0] CHAR_RDENY = 8'h4C;  // 'L'
  localparam logic [SEC_W-1:0] CHAR_NONE  = 8'h00;

  typedef enum logic [1:0] {
    LVL_OPEN   = 2'd0,
    LVL_WPROT  = 2'd1,
    LVL_RWPROT = 2'd2
  } lvl_t;

  typedef enum logic [CLASS_W-1:0] {
    CMD_MEM_WR  = 4'd0,
    CMD_MEM_RD  = 4'd1,
    CMD_CFG_WR  = 4'd2,
    CMD_CFG_RD  = 4'd3,
    CMD_SEC_WR  = 4'd4,
    CMD_BLK_ERS = 4'd5,
    CMD_ALL_ERS = 4'd6,
    CMD_BLANK   = 4'd7,
    CMD_INFO_RD = 4'd8
  } cmd_t;

  typedef struct packed {
    logic secWr;
    logic cfgStatus;
    logic cfgVector;
    logic wipe;
  } dpStrobe_t;

  // Unknown encodings fall to the strictest level.
  function automatic lvl_t lvlOf(input logic [SEC_W-1:0] b);
    case (b)
      CODE_OPEN:  lvlOf = LVL_OPEN;
      CODE_WPROT: lvlOf = LVL_WPROT;
      default:    lvlOf = LVL_RWPROT;
    endcase
  endfunction

  function automatic logic [SEC_W-1:0] codeOf(input lvl_t l);
    case (l)
      LVL_OPEN:  codeOf = CODE_OPEN;
      LVL_WPROT: codeOf = CODE_WPROT;
      default:   codeOf = CODE_RWPROT;
    endcase
  endfunction

endpackage

// File: rtl/secLevelDec.sv
module secLevelDec
  import secGatePkg::*;
#(
  parameter int BYTE_W = SEC_W
) (
  input  logic [BYTE_W-1:0] codeIn,
  output lvl_t              levelOut
);

  localparam int PAD_W = SEC_W - BYTE_W;

  logic [SEC_W-1:0] codeWide;

  generate
    if (PAD_W > 0) begin : g_pad
      assign codeWide = {{PAD_W{1'b1}}, codeIn};
    end else begin : g_nopad
      assign codeWide = codeIn[SEC_W-1:0];
    end
  endgenerate

  assign levelOut = lvlOf(codeWide);

endmodule

// File: rtl/secGateCtrl.sv
module secGateCtrl
  import secGatePkg::*;
#(
  parameter int BYTE_W  = SEC_W,
  parameter int CLS_W   = CLASS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CLS_W-1:0]  reqClass,
  input  logic              reqSel,
  input  logic [BYTE_W-1:0] reqData,
  input  lvl_t              curLevel,
  output dpStrobe_t         strb,
  output logic              respValid,
  output logic              respAllow,
  output logic [BYTE_W-1:0] respChar
);

  lvl_t reqLevel;
  logic reqCodeOk;
  logic allowNow;
  logic readKind;
  logic isSecWr;
  logic isCfgWr;
  logic isWipe;

  secLevelDec #(.BYTE_W(BYTE_W)) u_reqDec (
    .codeIn  (reqData),
    .levelOut(reqLevel)
  );

  // A requested byte is valid only if it re-encodes to itself.
  assign reqCodeOk = (reqData == codeOf(reqLevel));

  always_comb begin
    allowNow = 1'b0;
    readKind = 1'b0;
    isSecWr  = 1'b0;
    isCfgWr  = 1'b0;
    isWipe   = 1'b0;
    case (reqClass)
      CMD_MEM_WR:  allowNow = (curLevel == LVL_OPEN);
      CMD_CFG_WR: begin
        allowNow = (curLevel == LVL_OPEN);
        isCfgWr  = 1'b1;
      end
      CMD_MEM_RD, CMD_CFG_RD: begin
        allowNow = (curLevel != LVL_RWPROT);
        readKind = 1'b1;
      end
      CMD_SEC_WR: begin
        allowNow = reqCodeOk && (reqLevel > curLevel);
        isSecWr  = 1'b1;
      end
      CMD_BLK_ERS: allowNow = (curLevel == LVL_OPEN);
      CMD_ALL_ERS: begin
        allowNow = 1'b1;
        isWipe   = 1'b1;
      end
      CMD_BLANK, CMD_INFO_RD: allowNow = 1'b1;
      default: allowNow = 1'b0;
    endcase
  end

  always_comb begin
    strb.secWr     = reqValid && allowNow && isSecWr;
    strb.cfgStatus = reqValid && allowNow && isCfgWr && !reqSel;
    strb.cfgVector = reqValid && allowNow && isCfgWr && reqSel;
    strb.wipe      = reqValid && allowNow && isWipe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respAllow <= 1'b0;
      respChar  <= '0;
    end else begin
      respValid <= reqValid;
      respAllow <= reqValid && allowNow;
      if (reqValid && !allowNow)
        respChar <= readKind ? CHAR_RDENY[BYTE_W-1:0] : CHAR_WDENY[BYTE_W-1:0];
      else
        respChar <= CHAR_NONE[BYTE_W-1:0];
    end
  end

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R2

  AST_DENY_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respAllow) |-> (respChar == CHAR_WDENY[BYTE_W-1:0] ||
                                   respChar == CHAR_RDENY[BYTE_W-1:0])); // R2

  AST_READ_AT_L1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqClass == CMD_MEM_RD && curLevel == LVL_WPROT) |=> respAllow); // R3

  AST_READ_LOCK_L2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqClass == CMD_MEM_RD && curLevel == LVL_RWPROT)
      |=> (!respAllow && respChar == CHAR_RDENY[BYTE_W-1:0])); // R4

  AST_FULL_ERASE_OK: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqClass == CMD_ALL_ERS) |=> (respValid && respAllow)); // R5

  AST_BLOCK_ERASE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqClass == CMD_BLK_ERS && curLevel != LVL_OPEN) |=> !respAllow); // R5

  AST_UNDEF_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqClass > CMD_INFO_RD) |=> (!respAllow && respChar == CHAR_WDENY[BYTE_W-1:0])); // R11

endmodule

// File: rtl/secGateData.sv
module secGateData
  import secGatePkg::*;
#(
  parameter int              BYTE_W   = SEC_W,
  parameter logic [BYTE_W-1:0] SSB_INIT = CODE_OPEN[BYTE_W-1:0],
  parameter logic [BYTE_W-1:0] BSB_INIT = 8'hFF,
  parameter logic [BYTE_W-1:0] SBV_INIT = 8'hFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [BYTE_W-1:0] reqData,
  input  logic              loadValid,
  input  logic [BYTE_W-1:0] loadData,
  output logic [BYTE_W-1:0] secByte,
  output logic [BYTE_W-1:0] bootStatus,
  output logic [BYTE_W-1:0] bootVector
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secByte <= SSB_INIT;
    end else if (loadValid) begin
      secByte <= loadData;
    end else if (strb.wipe) begin
      secByte <= CODE_OPEN[BYTE_W-1:0];
    end else if (strb.secWr) begin
      secByte <= reqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootStatus <= BSB_INIT;
      bootVector <= SBV_INIT;
    end else if (strb.wipe) begin
      bootStatus <= BSB_INIT;
      bootVector <= SBV_INIT;
    end else begin
      if (strb.cfgStatus) bootStatus <= reqData;
      if (strb.cfgVector) bootVector <= reqData;
    end
  end

  AST_WIPE_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wipe && !loadValid) |=> (secByte == CODE_OPEN[BYTE_W-1:0] &&
                                   bootStatus == BSB_INIT && bootVector == SBV_INIT)); // R6

  AST_LEVEL_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wipe && !loadValid) |=> (lvlOf(secByte) >= lvlOf($past(secByte)))); // R7

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> (secByte == $past(loadData))); // R9

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wipe && !strb.cfgStatus) |=> $stable(bootStatus)); // R8

endmodule

// File: rtl/secGate.sv
module secGate
  import secGatePkg::*;
#(
  parameter int                BYTE_W   = SEC_W,
  parameter int                CLS_W    = CLASS_W,
  parameter logic [BYTE_W-1:0] SSB_INIT = CODE_OPEN[BYTE_W-1:0],
  parameter logic [BYTE_W-1:0] BSB_INIT = 8'hFF,
  parameter logic [BYTE_W-1:0] SBV_INIT = 8'hFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [CLS_W-1:0]  reqClass,
  input  logic              reqSel,
  input  logic [BYTE_W-1:0] reqData,
  input  logic              loadValid,
  input  logic [BYTE_W-1:0] loadData,
  output logic              respValid,
  output logic              respAllow,
  output logic [BYTE_W-1:0] respChar,
  output logic [1:0]        secLevel,
  output logic [BYTE_W-1:0] secByte,
  output logic [BYTE_W-1:0] bootStatus,
  output logic [BYTE_W-1:0] bootVector
);

  dpStrobe_t strb;
  lvl_t      curLevel;

  secLevelDec #(.BYTE_W(BYTE_W)) u_curDec (
    .codeIn  (secByte),
    .levelOut(curLevel)
  );

  assign secLevel = curLevel;

  secGateCtrl #(.BYTE_W(BYTE_W), .CLS_W(CLS_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqClass (reqClass),
    .reqSel   (reqSel),
    .reqData  (reqData),
    .curLevel (curLevel),
    .strb     (strb),
    .respValid(respValid),
    .respAllow(respAllow),
    .respChar (respChar)
  );

  secGateData #(
    .BYTE_W  (BYTE_W),
    .SSB_INIT(SSB_INIT),
    .BSB_INIT(BSB_INIT),
    .SBV_INIT(SBV_INIT)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqData   (reqData),
    .loadValid (loadValid),
    .loadData  (loadData),
    .secByte   (secByte),
    .bootStatus(bootStatus),
    .bootVector(bootVector)
  );

endmodule

// File: tb/sim_secGate.sv
`timescale 1ns/1ps
module sim_secGate;

  logic       clk = 1'b0;
  logic       rstN;
  logic       reqValid;
  logic [3:0] reqClass;
  logic       reqSel;
  logic [7:0] reqData;
  logic       loadValid;
  logic [7:0] loadData;
  logic       respValid;
  logic       respAllow;
  logic [7:0] respChar;
  logic [1:0] secLevel;
  logic [7:0] secByte;
  logic [7:0] bootStatus;
  logic [7:0] bootVector;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  secGate u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqClass(reqClass),
    .reqSel(reqSel), .reqData(reqData), .loadValid(loadValid), .loadData(loadData),
    .respValid(respValid), .respAllow(respAllow), .respChar(respChar),
    .secLevel(secLevel), .secByte(secByte), .bootStatus(bootStatus),
    .bootVector(bootVector)
  );

  // {preload, class, allow, data, char, requirement}
  localparam int NV = 27;
  localparam logic [39:0] VEC [NV] = '{
    40'hFF_0_1_00_00_02,  // R2 open write
    40'hFF_1_1_00_00_02,  // R2 open read
    40'hFE_0_0_00_50_03,  // R3
    40'hFE_1_1_00_00_03,  // R3
    40'hFE_2_0_00_50_03,  // R3
    40'hFE_3_1_00_00_03,  // R3
    40'hFC_1_0_00_4C_04,  // R4
    40'hFC_0_0_00_50_04,  // R4
    40'hFC_3_0_00_4C_04,  // R4
    40'hFC_2_0_00_50_04,  // R4
    40'hFF_5_1_00_00_05,  // R5
    40'hFE_5_0_00_50_05,  // R5
    40'hFC_5_0_00_50_05,  // R5
    40'hFC_7_1_00_00_05,  // R5
    40'hFC_8_1_00_00_05,  // R5
    40'hFE_6_1_00_00_05,  // R5
    40'h5A_1_0_00_4C_01,  // R1 invalid byte
    40'h5A_0_0_00_50_01,  // R1
    40'hFF_4_1_FE_00_07,  // R7
    40'hFF_4_1_FC_00_07,  // R7
    40'hFE_4_1_FC_00_07,  // R7
    40'hFE_4_0_FE_50_07,  // R7 same level
    40'hFE_4_0_FF_50_07,  // R7 lower
    40'hFC_4_0_FC_50_07,  // R7
    40'hFF_4_0_12_50_07,  // R7 bad encoding
    40'hFF_9_0_00_50_0B,  // R11
    40'hFC_F_0_00_50_0B   // R11
  };

  function automatic logic [1:0] expLevel(input logic [7:0] b);
    if (b == 8'hFF) return 2'd0;
    if (b == 8'hFE) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic doLoad(input logic [7:0] v);
    @(negedge clk);
    loadValid = 1'b1;
    loadData  = v;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  // Drive one request for one cycle; on return the response is settled.
  task automatic doReq(input logic [3:0] cls, input logic sel, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1;
    reqClass = cls;
    reqSel   = sel;
    reqData  = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqClass = '0; reqSel = 1'b0; reqData = '0;
    loadValid = 1'b0; loadData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10", "secByte", secByte, 8'hFF);
    check("R10", "bootStatus", bootStatus, 8'hFF);
    check("R10", "bootVector", bootVector, 8'hFC);
    check("R10", "respValid", {7'd0, respValid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] pre, d, ch, expByte;
      logic [3:0] cls;
      logic       al;
      string      rq;
      pre = VEC[i][39:32]; cls = VEC[i][31:28]; al = VEC[i][24];
      d = VEC[i][23:16]; ch = VEC[i][15:8];
      rq = $sformatf("R%0d", VEC[i][7:0]);
      doLoad(pre);
      check("R1", "secLevel", {6'd0, secLevel}, {6'd0, expLevel(pre)});
      doReq(cls, 1'b0, d);
      check(rq, $sformatf("vec%0d allow", i), {7'd0, respAllow}, {7'd0, al});
      check(rq, $sformatf("vec%0d char", i), respChar, ch);
      expByte = pre;
      if (al && cls == 4'd6) expByte = 8'hFF;
      if (al && cls == 4'd4) expByte = d;
      check(rq, $sformatf("vec%0d secByte", i), secByte, expByte);
    end

    // R2 response lasts one cycle
    @(negedge clk);
    check("R2", "respValid drop", {7'd0, respValid}, 8'h00);

    // R8 configuration writes
    doLoad(8'hFF);
    doReq(4'd2, 1'b0, 8'h12);
    check("R8", "bootStatus write", bootStatus, 8'h12);
    doReq(4'd2, 1'b1, 8'h34);
    check("R8", "bootVector write", bootVector, 8'h34);
    check("R8", "bootStatus kept", bootStatus, 8'h12);
    doLoad(8'hFE);
    doReq(4'd2, 1'b0, 8'h99);
    check("R8", "denied write", bootStatus, 8'h12);
    doReq(4'd2, 1'b1, 8'h99);
    check("R8", "denied vector", bootVector, 8'h34);

    // R6 full erase from level 2
    doLoad(8'hFC);
    doReq(4'd6, 1'b0, 8'h00);
    check("R6", "secByte", secByte, 8'hFF);
    check("R6", "bootStatus", bootStatus, 8'hFF);
    check("R6", "bootVector", bootVector, 8'hFC);
    check("R6", "secLevel", {6'd0, secLevel}, 8'h00);

    // R9 load beats same-cycle security write
    @(negedge clk);
    loadValid = 1'b1; loadData = 8'hFE;
    reqValid = 1'b1; reqClass = 4'd4; reqData = 8'hFC;
    @(negedge clk);
    loadValid = 1'b0; reqValid = 1'b0;
    check("R9", "load priority", secByte, 8'hFE);
    doLoad(8'hFF);
    check("R9", "load lowers", secByte, 8'hFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule